// File: doc/BRIEF.md
# MAC Interrupt Event, Mask and Receive Doorbell Registers

This block is the interrupt and doorbell corner of a MAC controller's register space. A simple 32-bit register bus reaches it. The MAC delivers thirteen single-cycle event pulses, and each pulse latches into a write-1-to-clear event register. A read/write mask register sits beside the event register. One level-sensitive interrupt line is raised whenever an event bit and its mask bit are both set. That line stays high until software acknowledges the event or masks it.

A receive doorbell register tells the descriptor-polling engine that fresh empty buffers are waiting. Any bus write to the doorbell address arms an active flag, whatever data is written. The flag is kept by a two-state machine:

- `DB_IDLE` moves to `DB_ACTIVE` on a doorbell write (transition ARM).
- `DB_ACTIVE` moves to `DB_IDLE` on a clear pulse from the polling engine when no doorbell write happens in the same cycle (transition RETIRE).
- Every other case keeps the current state (transition HOLD).

Top module: `mac_irq_regblk`

## Requirements
- R1: After reset, reads of the event register, the mask register and the doorbell register all return 0, and `irq_o` is low.
- R2: A pulse on `evt_pulse_i[i]` sets event register bit 19+i. The sources, from bit 31 down to bit 19, are: heartbeat error, babbling receive, babbling transmit, graceful stop complete, transmit frame, transmit buffer, receive frame, receive buffer, management transfer, bus error, late collision, retry limit and underrun.
- R3: A write to the event register (offset 0x04) clears every implemented bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If an event pulse and a software clear hit the same bit in the same cycle, the bit stays set.
- R5: The mask register (offset 0x08) stores bits 31:19 as written. Bits 18:0 of both the event register and the mask register always read 0.
- R6: `irq_o` is high exactly when some bit is set in both the event register and the mask register. A mask bit of 0 blocks its source.
- R7: Once `irq_o` is high, it stays high until software clears the event bit or writes 0 to the mask bit.
- R8: Any write to the doorbell register (offset 0x10), including a write of all zeros, sets the active flag. The flag reads back on bit 24 of the doorbell register and drives `rx_active_o`.
- R9: A `rx_poll_clr_i` pulse clears the active flag. A doorbell write in the same cycle wins, and the flag stays set.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Bus access strobe |
| reg_we | input | 1 | Write qualifier for the access |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse_i | input | 13 | Event pulses from the MAC, index i feeding bit 19+i |
| rx_poll_clr_i | input | 1 | Clear pulse from the descriptor-polling engine |
| rx_active_o | output | 1 | Receive descriptor active flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
A corrupted event or mask bit shows on `irq_o` in the same cycle it is registered, because the interrupt is a pure AND-OR of the two registers. The same fault also shows on the very next read of either register, so every check pairs an interrupt-level sample with a readback. A doorbell state machine stuck in the wrong state appears on `rx_active_o` one edge after the ARM or RETIRE stimulus. The bench therefore samples the flag after each such stimulus, including the case where a write and a clear arrive together.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
    typedef enum logic {
        DB_IDLE   = 1'b0,
        DB_ACTIVE = 1'b1
    } db_state_e;
endpackage

// File: rtl/mac_irq_event_bank.sv
module mac_irq_event_bank #(
    parameter int N_SRC = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_pulse,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_bits,
    output logic [N_SRC-1:0] evt_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                evt_q[i] <= 1'b0;
            else if (src_pulse[i])
                evt_q[i] <= 1'b1;
            else if (clr_we && clr_bits[i])
                evt_q[i] <= 1'b0;
        end
    end

    AST_PULSE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((evt_q & $past(src_pulse)) == $past(src_pulse))); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((evt_q & $past(clr_bits & ~src_pulse)) == '0)); // R3
endmodule

// File: rtl/mac_irq_doorbell.sv
module mac_irq_doorbell
    import mac_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic db_wr,
    input  logic poll_clr,
    output logic active
);
    db_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DB_IDLE:   if (db_wr) state_d = DB_ACTIVE;
            DB_ACTIVE: if (poll_clr && !db_wr) state_d = DB_IDLE;
            default:   state_d = DB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DB_IDLE;
        else        state_q <= state_d;
    end

    always_comb active = (state_q == DB_ACTIVE);

    AST_DB_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        db_wr |=> active); // R8

    AST_DB_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_clr && !db_wr) |=> !active); // R9
endmodule

// File: rtl/mac_irq_regblk.sv
module mac_irq_regblk #(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter int          N_SRC    = 13,
    parameter int          DB_BIT   = 24,
    parameter logic [7:0]  EVT_OFS  = 8'h04,
    parameter logic [7:0]  MASK_OFS = 8'h08,
    parameter logic [7:0]  DB_OFS   = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  evt_pulse_i,
    input  logic              rx_poll_clr_i,
    output logic              rx_active_o,
    output logic              irq_o
);
    localparam int SRC_LSB = DATA_W - N_SRC;
    localparam logic [DATA_W-1:0] IMPL_MASK = {{N_SRC{1'b1}}, {SRC_LSB{1'b0}}};

    logic             wr_evt, wr_mask, wr_db;
    logic [N_SRC-1:0] evt_q, mask_q;
    logic [N_SRC-1:0] wr_field;

    always_comb begin
        wr_field = reg_wdata[DATA_W-1:SRC_LSB];
        wr_evt   = reg_en && reg_we && (reg_addr == EVT_OFS[ADDR_W-1:0]);
        wr_mask  = reg_en && reg_we && (reg_addr == MASK_OFS[ADDR_W-1:0]);
        wr_db    = reg_en && reg_we && (reg_addr == DB_OFS[ADDR_W-1:0]);
    end

    mac_irq_event_bank #(.N_SRC(N_SRC)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (evt_pulse_i),
        .clr_we    (wr_evt),
        .clr_bits  (wr_field),
        .evt_q     (evt_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wr_field;
    end

    mac_irq_doorbell u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .db_wr    (wr_db),
        .poll_clr (rx_poll_clr_i),
        .active   (rx_active_o)
    );

    always_comb irq_o = |(evt_q & mask_q);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            EVT_OFS[ADDR_W-1:0]:  reg_rdata[DATA_W-1:SRC_LSB] = evt_q;
            MASK_OFS[ADDR_W-1:0]: reg_rdata[DATA_W-1:SRC_LSB] = mask_q;
            DB_OFS[ADDR_W-1:0]:   reg_rdata[DB_BIT]           = rx_active_o;
            default:              reg_rdata = '0;
        endcase
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_evt && !wr_mask) |=> irq_o); // R7

    AST_MASK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> ((reg_addr != MASK_OFS[ADDR_W-1:0]) ||
                     (reg_rdata == ($past(reg_wdata) & IMPL_MASK)))); // R5

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o); // R6
endmodule

// File: tb/mac_irq_regblk_bench.sv
`timescale 1ns/1ps
module mac_irq_regblk_bench;
    localparam logic [7:0] A_EVT = 8'h04, A_MASK = 8'h08, A_DB = 8'h10, A_NONE = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [12:0] evt_pulse_i = '0;
    logic        rx_poll_clr_i = 1'b0, rx_active_o, irq_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mac_irq_regblk u_mac_irq_regblk (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse_i(evt_pulse_i), .rx_poll_clr_i(rx_poll_clr_i),
        .rx_active_o(rx_active_o), .irq_o(irq_o)
    );

    // {pulses[12:0], w1c data[31:0], expected event readback[31:0]}
    localparam logic [76:0] VEC [6] = '{
        {13'h1000, 32'h0000_0000, 32'h8000_0000},
        {13'h0001, 32'h0000_0000, 32'h0008_0000},
        {13'h1FFF, 32'h0000_0000, 32'hFFF8_0000},
        {13'h1FFF, 32'h8000_0000, 32'h7FF8_0000},
        {13'h0040, 32'h0000_FFFF, 32'h0200_0000},
        {13'h0155, 32'hFFF8_0000, 32'h0000_0000}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 0;
    endtask

    task automatic pulse(logic [12:0] p);
        @(negedge clk); evt_pulse_i = p;
        @(negedge clk); evt_pulse_i = '0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(A_EVT, r);  check("R1 event", r, 0);
        rd(A_MASK, r); check("R1 mask", r, 0);
        rd(A_DB, r);   check("R1 doorbell", r, 0);
        check("R1 irq", {31'b0, irq_o}, 0);

        // R2 R3 table walk
        for (int k = 0; k < 6; k++) begin
            wr(A_EVT, 32'hFFFF_FFFF);
            pulse(VEC[k][76:64]);
            wr(A_EVT, VEC[k][63:32]);
            rd(A_EVT, r);
            check($sformatf("R2/R3 vector %0d", k), r, VEC[k][31:0]);
        end

        // R5 mask readback, reserved bits zero
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, r); check("R5 mask readback", r, 32'hFFF8_0000);
        wr(A_MASK, 32'h0000_0000);

        // R4 pulse and clear in the same cycle
        wr(A_EVT, 32'hFFFF_FFFF);
        @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = A_EVT;
        reg_wdata = 32'h0400_0000; evt_pulse_i = 13'h0080;
        @(negedge clk); reg_en = 0; reg_we = 0; evt_pulse_i = '0;
        rd(A_EVT, r); check("R4 event wins", r, 32'h0400_0000);
        wr(A_EVT, 32'hFFFF_FFFF);

        // R6 masking
        wr(A_MASK, 32'h8000_0000);
        pulse(13'h0001);
        check("R6 masked source blocked", {31'b0, irq_o}, 0);
        pulse(13'h1000);
        check("R6 enabled source raises irq", {31'b0, irq_o}, 1);
        // R7 holds
        repeat (5) @(negedge clk);
        check("R7 irq held", {31'b0, irq_o}, 1);
        wr(A_MASK, 32'h0000_0000);
        check("R7 mask zero drops irq", {31'b0, irq_o}, 0);
        wr(A_MASK, 32'h8000_0000);
        check("R7 unmask restores irq", {31'b0, irq_o}, 1);
        wr(A_EVT, 32'h8000_0000);
        check("R7 w1c drops irq", {31'b0, irq_o}, 0);
        rd(A_EVT, r); check("R3 other bit kept", r, 32'h0008_0000);

        // R8 doorbell with zero data
        wr(A_DB, 32'h0000_0000);
        check("R8 active flag", {31'b0, rx_active_o}, 1);
        rd(A_DB, r); check("R8 doorbell readback", r, 32'h0100_0000);
        // R9 poll clear
        @(negedge clk); rx_poll_clr_i = 1;
        @(negedge clk); rx_poll_clr_i = 0;
        check("R9 poll clear", {31'b0, rx_active_o}, 0);
        @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = A_DB;
        reg_wdata = 32'h1234_5678; rx_poll_clr_i = 1;
        @(negedge clk); reg_en = 0; reg_we = 0; rx_poll_clr_i = 0;
        check("R9 write wins over clear", {31'b0, rx_active_o}, 1);

        // R10 unmapped offset
        wr(A_NONE, 32'hFFFF_FFFF);
        rd(A_NONE, r); check("R10 unmapped reads zero", r, 0);
        rd(A_MASK, r); check("R10 mask untouched", r, 32'h8000_0000);
        rd(A_EVT, r);  check("R10 event untouched", r, 32'h0008_0000);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule